// File: doc/BRIEF.md
# Coprocessor Run-Control Status Register

This block holds the run-control state of a small vector coprocessor: the halt and break flags, an interrupt-on-break enable, eight general signal flags and the coprocessor interrupt line. The host bus and the core's own writeback stage both write to it, and each write carries a command word. In that word every flag has its own clear bit and set bit, so one write can change several flags and leave the others as they are. When a BREAK instruction reaches writeback, the block applies a command of its own that sets halt and broke. That command uses a set-broke bit that only the break path can produce. A break in a delay slot therefore stops the core before the branch target runs, and clearing halt later resumes the core at that target.

The block gives the core a run enable and a same-cycle freeze, which stops the later pipeline stages on the cycle a writeback write halts the core. It also gives a flush strobe with a fetch address. The host can only redirect the program counter while the core is halted. Clearing halt restarts the core at the instruction held in its read/execute latch.

Top module: `cop_runctl`

## Requirements
- R1: After reset, halt reads 1, and broke, interrupt-on-break, all signal flags, the interrupt line, flush and the PC error flag read 0. The fetch PC reads 0.
- R2: Command bits are: bit 0 clear halt, bit 1 set halt, bit 2 clear broke, bit 3 clear interrupt, bit 4 set interrupt, bit 7 clear interrupt-on-break, bit 8 set interrupt-on-break. For signal n, bit 9+2n clears it and bit 10+2n sets it (signal 6 set is bit 22, signal 7 clear is bit 23, signal 7 set is bit 24). A flag with neither bit is unchanged. A flag with both bits is cleared. The result shows in the next cycle.
- R3: The status readback word has halt at bit 0, broke at bit 1, interrupt-on-break at bit 6 and signal n at bit 7+n. All other bits read 0.
- R4: Bit 31 is the set-broke command. It is removed from every host status write and every move-to-coprocessor write, so neither of these can set broke.
- R5: A BREAK at writeback applies set-halt together with set-broke. Commands written in the same cycle are merged with it by OR, and clear still wins. A host clear-broke in the same cycle therefore leaves broke at 0 while halt becomes 1.
- R6: In a cycle with a writeback-stage write (a BREAK or a move-to-coprocessor write) whose result leaves halt set, the freeze output is 1 in that same cycle. A host write never raises freeze.
- R7: The interrupt line is set in the next cycle by the set-interrupt command, or by a BREAK while interrupt-on-break is 1. It is cleared by the clear-interrupt command, which wins over either set source.
- R8: A clear-halt command while halt is 1 gives a one-cycle flush pulse in the next cycle and loads the fetch PC from the read/execute-latch PC. A clear-halt while the core is running gives no flush.
- R9: A host PC write while halted gives a flush pulse in the next cycle and loads the fetch PC with the write data with its two low bits cleared. This write takes precedence over a clear-halt restore in the same cycle.
- R10: A host PC write while running changes neither the fetch PC nor flush. It sets a sticky PC error flag that only reset clears.
- R11: Run enable is always the inverse of halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stat_we | input | 1 | Host write to the status command register |
| host_stat_wdata | input | 32 | Host command word |
| mtc0_we | input | 1 | Move-to-coprocessor status write at writeback |
| mtc0_wdata | input | 32 | Command word from the core |
| wb_break | input | 1 | BREAK instruction at writeback |
| rdex_pc | input | 12 | PC held in the core's read/execute latch |
| host_pc_we | input | 1 | Host write to the program counter |
| host_pc_wdata | input | 12 | Host program counter value |
| status_rd | output | 32 | Status readback word |
| irq | output | 1 | Coprocessor interrupt request |
| run_en | output | 1 | Core run enable |
| freeze | output | 1 | Same-cycle stall of the later pipeline stages |
| flush | output | 1 | Pipeline flush strobe |
| fetch_pc | output | 12 | Fetch address, valid with flush |
| pc_err | output | 1 | Sticky flag for a PC write while running |

## Verification
The hardest cases are those where several sources act in the same cycle. Examples are a BREAK that meets a host clear-broke, and a host PC write that meets a clear-halt while the core is halted. Only the precedence rules decide the result there. The stimulus drives these collisions on purpose, on single cycles. It also reaches the running state first through a clear-halt, so that the freeze, the ignored PC write and the break-raised interrupt can all be seen. A behavioural model in the bench predicts every output on every clock.

// File: rtl/cop_runctl_pkg.sv
package cop_runctl_pkg;
  // command word bit positions
  localparam int CB_CLR_HALT  = 0;
  localparam int CB_SET_HALT  = 1;
  localparam int CB_CLR_BROKE = 2;
  localparam int CB_CLR_IRQ   = 3;
  localparam int CB_SET_IRQ   = 4;
  localparam int CB_CLR_IOB   = 7;
  localparam int CB_SET_IOB   = 8;
  localparam int CB_SIG_BASE  = 9;
  localparam int CB_SET_BROKE = 31;

  // readback word bit positions
  localparam int RB_HALT     = 0;
  localparam int RB_BROKE    = 1;
  localparam int RB_IOB      = 6;
  localparam int RB_SIG_BASE = 7;

  // paired command update: clear dominates set
  function automatic logic pair_next(input logic cur, input logic set_c, input logic clr_c);
    if (clr_c) return 1'b0;
    if (set_c) return 1'b1;
    return cur;
  endfunction

  // strip the internal-only set-broke command from an external word
  function automatic logic [31:0] ext_word(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    r[CB_SET_BROKE] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/cop_cmd_merge.sv
module cop_cmd_merge
  import cop_runctl_pkg::*;
#(
  parameter int NUM_SIG = 8
) (
  input  logic               host_we,
  input  logic [31:0]        host_wdata,
  input  logic               mtc0_we,
  input  logic [31:0]        mtc0_wdata,
  input  logic               wb_break,
  output logic               wb_active,
  output logic               c_clr_halt,
  output logic               c_set_halt,
  output logic               c_clr_broke,
  output logic               c_set_broke,
  output logic               c_clr_irq,
  output logic               c_set_irq,
  output logic               c_clr_iob,
  output logic               c_set_iob,
  output logic [NUM_SIG-1:0] c_sig_clr,
  output logic [NUM_SIG-1:0] c_sig_set
);
  localparam int SIG_TOP = CB_SIG_BASE + 2 * NUM_SIG;

  logic [31:0] host_cmd, core_cmd, brk_cmd, all_cmd;

  always_comb begin
    host_cmd = host_we ? ext_word(host_wdata) : 32'h0;
    core_cmd = mtc0_we ? ext_word(mtc0_wdata) : 32'h0;
    brk_cmd  = 32'h0;
    if (wb_break) begin
      brk_cmd[CB_SET_HALT]  = 1'b1;
      brk_cmd[CB_SET_BROKE] = 1'b1;
    end
    all_cmd = host_cmd | core_cmd | brk_cmd;
  end

  assign wb_active   = mtc0_we | wb_break;
  assign c_clr_halt  = all_cmd[CB_CLR_HALT];
  assign c_set_halt  = all_cmd[CB_SET_HALT];
  assign c_clr_broke = all_cmd[CB_CLR_BROKE];
  assign c_set_broke = all_cmd[CB_SET_BROKE];
  assign c_clr_irq   = all_cmd[CB_CLR_IRQ];
  assign c_set_irq   = all_cmd[CB_SET_IRQ];
  assign c_clr_iob   = all_cmd[CB_CLR_IOB];
  assign c_set_iob   = all_cmd[CB_SET_IOB];

  for (genvar n = 0; n < NUM_SIG; n++) begin : g_sig
    assign c_sig_clr[n] = all_cmd[CB_SIG_BASE + 2*n];
    assign c_sig_set[n] = all_cmd[CB_SIG_BASE + 2*n + 1];
  end

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{all_cmd[30:SIG_TOP], all_cmd[6:5]};
endmodule

// File: rtl/cop_stat_flags.sv
module cop_stat_flags
  import cop_runctl_pkg::*;
#(
  parameter int NUM_SIG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wb_active,
  input  logic               wb_break,
  input  logic               c_clr_halt,
  input  logic               c_set_halt,
  input  logic               c_clr_broke,
  input  logic               c_set_broke,
  input  logic               c_clr_irq,
  input  logic               c_set_irq,
  input  logic               c_clr_iob,
  input  logic               c_set_iob,
  input  logic [NUM_SIG-1:0] c_sig_clr,
  input  logic [NUM_SIG-1:0] c_sig_set,
  output logic               halt,
  output logic               broke,
  output logic               iob,
  output logic               irq,
  output logic [NUM_SIG-1:0] sig,
  output logic               halt_next,
  output logic               freeze_ev,
  output logic               restore_ev
);
  logic brk_irq;

  assign halt_next  = pair_next(halt, c_set_halt, c_clr_halt);
  assign freeze_ev  = wb_active & halt_next;
  assign restore_ev = halt & c_clr_halt;
  assign brk_irq    = wb_break & iob;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt  <= 1'b1;
      broke <= 1'b0;
      iob   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      halt  <= halt_next;
      broke <= pair_next(broke, c_set_broke, c_clr_broke);
      iob   <= pair_next(iob, c_set_iob, c_clr_iob);
      irq   <= pair_next(irq, c_set_irq | brk_irq, c_clr_irq);
    end
  end

  for (genvar n = 0; n < NUM_SIG; n++) begin : g_sig
    always_ff @(posedge clk) begin
      if (!rst_n) sig[n] <= 1'b0;
      else        sig[n] <= pair_next(sig[n], c_sig_set[n], c_sig_clr[n]);
    end
  end
endmodule

// File: rtl/cop_pc_ctrl.sv
module cop_pc_ctrl #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic            restore_ev,
  input  logic            host_pc_we,
  input  logic [PC_W-1:0] host_pc_wdata,
  input  logic [PC_W-1:0] rdex_pc,
  output logic            flush,
  output logic [PC_W-1:0] fetch_pc,
  output logic            pc_err,
  output logic            host_load_ev,
  output logic            bad_pc_ev
);
  localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(3);

  assign host_load_ev = host_pc_we & halt;
  assign bad_pc_ev    = host_pc_we & ~halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush    <= 1'b0;
      fetch_pc <= '0;
      pc_err   <= 1'b0;
    end else begin
      flush  <= host_load_ev | restore_ev;
      pc_err <= pc_err | bad_pc_ev;
      if (host_load_ev)    fetch_pc <= host_pc_wdata & ALIGN_MASK;
      else if (restore_ev) fetch_pc <= rdex_pc;
    end
  end
endmodule

// File: rtl/cop_runctl.sv
module cop_runctl
  import cop_runctl_pkg::*;
#(
  parameter int NUM_SIG = 8,
  parameter int PC_W    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_stat_we,
  input  logic [31:0]     host_stat_wdata,
  input  logic            mtc0_we,
  input  logic [31:0]     mtc0_wdata,
  input  logic            wb_break,
  input  logic [PC_W-1:0] rdex_pc,
  input  logic            host_pc_we,
  input  logic [PC_W-1:0] host_pc_wdata,
  output logic [31:0]     status_rd,
  output logic            irq,
  output logic            run_en,
  output logic            freeze,
  output logic            flush,
  output logic [PC_W-1:0] fetch_pc,
  output logic            pc_err
);
  logic               wb_active;
  logic               c_clr_halt, c_set_halt, c_clr_broke, c_set_broke;
  logic               c_clr_irq, c_set_irq, c_clr_iob, c_set_iob;
  logic [NUM_SIG-1:0] c_sig_clr, c_sig_set;
  logic               halt, broke, iob;
  logic [NUM_SIG-1:0] sig;
  logic               halt_next, freeze_ev, restore_ev;
  logic               host_load_ev, bad_pc_ev;

  cop_cmd_merge #(.NUM_SIG(NUM_SIG)) u_merge (
    .host_we(host_stat_we), .host_wdata(host_stat_wdata),
    .mtc0_we(mtc0_we), .mtc0_wdata(mtc0_wdata), .wb_break(wb_break),
    .wb_active(wb_active),
    .c_clr_halt(c_clr_halt), .c_set_halt(c_set_halt),
    .c_clr_broke(c_clr_broke), .c_set_broke(c_set_broke),
    .c_clr_irq(c_clr_irq), .c_set_irq(c_set_irq),
    .c_clr_iob(c_clr_iob), .c_set_iob(c_set_iob),
    .c_sig_clr(c_sig_clr), .c_sig_set(c_sig_set)
  );

  cop_stat_flags #(.NUM_SIG(NUM_SIG)) u_flags (
    .clk(clk), .rst_n(rst_n), .wb_active(wb_active), .wb_break(wb_break),
    .c_clr_halt(c_clr_halt), .c_set_halt(c_set_halt),
    .c_clr_broke(c_clr_broke), .c_set_broke(c_set_broke),
    .c_clr_irq(c_clr_irq), .c_set_irq(c_set_irq),
    .c_clr_iob(c_clr_iob), .c_set_iob(c_set_iob),
    .c_sig_clr(c_sig_clr), .c_sig_set(c_sig_set),
    .halt(halt), .broke(broke), .iob(iob), .irq(irq), .sig(sig),
    .halt_next(halt_next), .freeze_ev(freeze_ev), .restore_ev(restore_ev)
  );

  cop_pc_ctrl #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .halt(halt), .restore_ev(restore_ev),
    .host_pc_we(host_pc_we), .host_pc_wdata(host_pc_wdata), .rdex_pc(rdex_pc),
    .flush(flush), .fetch_pc(fetch_pc), .pc_err(pc_err),
    .host_load_ev(host_load_ev), .bad_pc_ev(bad_pc_ev)
  );

  always_comb begin
    status_rd           = 32'h0;
    status_rd[RB_HALT]  = halt;
    status_rd[RB_BROKE] = broke;
    status_rd[RB_IOB]   = iob;
    for (int n = 0; n < NUM_SIG; n++) status_rd[RB_SIG_BASE + n] = sig[n];
  end

  assign run_en = ~halt;
  assign freeze = freeze_ev;
endmodule

// File: rtl/cop_runctl_chk.sv
module cop_runctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_stat_we,
  input logic [31:0] host_stat_wdata,
  input logic        mtc0_we,
  input logic [31:0] mtc0_wdata,
  input logic        wb_break,
  input logic        host_pc_we,
  input logic [31:0] status_rd,
  input logic        irq,
  input logic        run_en,
  input logic        freeze,
  input logic        flush,
  input logic        pc_err
);
  logic no_clr_halt;
  assign no_clr_halt = !(host_stat_we && host_stat_wdata[0]) && !(mtc0_we && mtc0_wdata[0]);

  // R5: a break with no competing clear-halt halts the core
  a_r5_break_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_break && no_clr_halt) |=> status_rd[0]);

  // R4: without a break, broke can never rise
  a_r4_no_ext_broke: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_break && !status_rd[1]) |=> !status_rd[1]);

  // R6: a freeze is always followed by a halted core
  a_r6_freeze_halts: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (status_rd[0] && !run_en));

  // R7: clear-interrupt from the host always drops the line
  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat_we && host_stat_wdata[3]) |=> !irq);

  // R8: a flush only follows a halted cycle
  a_r8_flush_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(status_rd[0]));

  // R10: a PC write while running causes no flush and the error stays
  a_r10_run_pc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pc_we && run_en) |=> (!flush && pc_err));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pc_err |=> pc_err);
endmodule

bind cop_runctl cop_runctl_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_stat_we(host_stat_we), .host_stat_wdata(host_stat_wdata),
  .mtc0_we(mtc0_we), .mtc0_wdata(mtc0_wdata), .wb_break(wb_break),
  .host_pc_we(host_pc_we), .status_rd(status_rd), .irq(irq),
  .run_en(run_en), .freeze(freeze), .flush(flush), .pc_err(pc_err)
);

// File: tb/sim_cop_runctl.sv
`timescale 1ns/1ps
module sim_cop_runctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_stat_we = 1'b0;
  logic [31:0] host_stat_wdata = '0;
  logic        mtc0_we = 1'b0;
  logic [31:0] mtc0_wdata = '0;
  logic        wb_break = 1'b0;
  logic [11:0] rdex_pc = '0;
  logic        host_pc_we = 1'b0;
  logic [11:0] host_pc_wdata = '0;
  logic [31:0] status_rd;
  logic        irq, run_en, freeze, flush, pc_err;
  logic [11:0] fetch_pc;

  int total = 0;
  int bad = 0;

  // reference model state
  bit       m_halt, m_broke, m_iob, m_irq, m_flush, m_err;
  bit [7:0] m_sig;
  bit [11:0] m_pc;

  always #2.5 clk = ~clk;

  cop_runctl u0 (
    .clk(clk), .rst_n(rst_n),
    .host_stat_we(host_stat_we), .host_stat_wdata(host_stat_wdata),
    .mtc0_we(mtc0_we), .mtc0_wdata(mtc0_wdata), .wb_break(wb_break),
    .rdex_pc(rdex_pc), .host_pc_we(host_pc_we), .host_pc_wdata(host_pc_wdata),
    .status_rd(status_rd), .irq(irq), .run_en(run_en), .freeze(freeze),
    .flush(flush), .fetch_pc(fetch_pc), .pc_err(pc_err)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive, compare everything, advance model
  task automatic step(input string tag, input bit hwe, input bit [31:0] hw,
                      input bit mwe, input bit [31:0] mw, input bit brk,
                      input bit pwe, input bit [11:0] pw, input bit [11:0] rpc);
    bit [31:0] c, exp_st;
    bit nh, set_i, frz;
    host_stat_we = hwe; host_stat_wdata = hw;
    mtc0_we = mwe; mtc0_wdata = mw; wb_break = brk;
    host_pc_we = pwe; host_pc_wdata = pw; rdex_pc = rpc;
    #1;
    // merged command: external words lose the top bit; a break adds halt+broke
    c = 0;
    if (hwe) c |= (hw & 32'h7FFF_FFFF);
    if (mwe) c |= (mw & 32'h7FFF_FFFF);
    if (brk) c |= 32'h8000_0002;
    nh = c[0] ? 1'b0 : (c[1] ? 1'b1 : m_halt);
    frz = (mwe || brk) && nh;
    exp_st = 0;
    exp_st[0] = m_halt; exp_st[1] = m_broke; exp_st[6] = m_iob;
    for (int i = 0; i < 8; i++) exp_st[7+i] = m_sig[i];
    check({tag, " status"}, status_rd, exp_st);
    check("R11 run_en", run_en, !m_halt);
    check("R6 freeze", freeze, frz);
    check("R7 irq", irq, m_irq);
    check("R8 flush", flush, m_flush);
    check("R9 fetch_pc", fetch_pc, m_pc);
    check("R10 pc_err", pc_err, m_err);
    @(posedge clk);
    set_i = c[4] || (brk && m_iob);
    m_flush = (pwe && m_halt) || (c[0] && m_halt);
    if (pwe && m_halt)       m_pc = pw & 12'hFFC;
    else if (c[0] && m_halt) m_pc = rpc;
    if (pwe && !m_halt) m_err = 1;
    m_irq   = c[3] ? 1'b0 : (set_i ? 1'b1 : m_irq);
    m_broke = c[2] ? 1'b0 : (c[31] ? 1'b1 : m_broke);
    m_iob   = c[7] ? 1'b0 : (c[8] ? 1'b1 : m_iob);
    for (int i = 0; i < 8; i++)
      m_sig[i] = c[9+2*i] ? 1'b0 : (c[10+2*i] ? 1'b1 : m_sig[i]);
    m_halt = nh;
    @(negedge clk);
  endtask

  task automatic hw(input string tag, input bit [31:0] w);
    step(tag, 1, w, 0, 0, 0, 0, 0, 12'h124);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 12'h124);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_halt = 1; m_broke = 0; m_iob = 0; m_irq = 0; m_flush = 0; m_err = 0;
    m_sig = 0; m_pc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    // R8: clear halt while halted restores the latch PC
    hw("R8", 32'h0000_0001);
    idle("R8");
    // R8: clear halt while running, no flush
    hw("R8", 32'h0000_0001);
    // R2 R3: set signal 7, signal 6 and interrupt-on-break
    hw("R2", (32'h1 << 24) | (32'h1 << 22) | (32'h1 << 8));
    idle("R3");
    // R2: both commands for signal 7 clear it
    hw("R2", (32'h1 << 23) | (32'h1 << 24) | (32'h1 << 9) | (32'h1 << 20));
    idle("R2");
    // R4: external set-broke bit is stripped
    hw("R4", 32'h8000_0000);
    step("R4", 0, 0, 1, 32'h8000_0000, 0, 0, 0, 12'h124);
    idle("R4");
    // R10: PC write while running
    step("R10", 0, 0, 0, 0, 0, 1, 12'h3F7, 12'h124);
    idle("R10");
    // R5 R6 R7: break with interrupt-on-break set
    step("R5", 0, 0, 0, 0, 1, 0, 0, 12'h200);
    idle("R7");
    // R9: PC write while halted
    step("R9", 0, 0, 0, 0, 0, 1, 12'hABF, 12'h200);
    idle("R9");
    // clear halt, broke, interrupt together
    hw("R7", 32'h0000_000D);
    idle("R2");
    // R5: break meets host clear-broke in the same cycle
    step("R5", 1, 32'h0000_0004, 0, 0, 1, 0, 0, 12'h088);
    idle("R5");
    // R9: PC write wins over clear-halt restore
    step("R9", 1, 32'h0000_0001, 0, 0, 0, 1, 12'h555, 12'h0F0);
    idle("R9");
    // R6: move-to-coprocessor set-halt freezes; host set-halt does not
    step("R6", 0, 0, 1, 32'h0000_0002, 0, 0, 0, 12'h010);
    hw("R6", 32'h0000_0001);
    hw("R6", 32'h0000_0002);
    idle("R6");
    // R7: set and clear interrupt together, then set alone, then clear
    hw("R7", 32'h0000_0018);
    hw("R7", 32'h0000_0010);
    idle("R7");
    hw("R7", 32'h0000_0008);
    // R7: interrupt-on-break cleared, break raises no interrupt
    hw("R7", 32'h0000_0081);
    step("R7", 0, 0, 0, 0, 1, 0, 0, 12'h040);
    idle("R7");
    // clear every signal
    hw("R2", 32'h00AA_AA00);
    idle("R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule